// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the purely combinational control decoder of a single-cycle processor that runs a six-instruction subset: register add, register subtract, OR with an immediate, word load, word store and branch-if-equal. It takes the 6-bit opcode and the 6-bit function field of the current instruction. From these it drives every datapath select and write enable: next-PC branch select, destination-register select, register write, extender mode, ALU operand-B source, ALU operation, data-memory write and write-back source.

The branch-if-equal instruction is handled by steering both register operands into the ALU and selecting subtract. No state is written. The fetch unit combines the branch select with the ALU zero flag and picks the branch target only when both are high. Any output that has no meaning for an instruction is driven to 0. An opcode or function code outside the subset drives every output to 0, so that no write can occur and the branch select stays low.

Top module: `ctl_main_decoder`

## Requirements
- R1: Opcode 000000 with function 100000 (add) gives reg_dst_o=1, reg_wr_o=1, ext_sign_o=0, alu_src_imm_o=0, alu_ctr_o=000 (add), mem_wr_o=0, mem_to_reg_o=0, branch_sel_o=0; the ALU codes are 000 add, 001 subtract, 010 OR.
- R2: Opcode 000000 with function 100010 (sub) gives the same outputs as R1 except alu_ctr_o=001.
- R3: Opcode 001101 (ori) gives reg_wr_o=1, alu_src_imm_o=1, alu_ctr_o=010, ext_sign_o=0 (zero extension); all other outputs are 0.
- R4: Opcode 100011 (lw) gives reg_wr_o=1, ext_sign_o=1, alu_src_imm_o=1, alu_ctr_o=000, mem_to_reg_o=1; all other outputs are 0.
- R5: Opcode 101011 (sw) gives mem_wr_o=1, ext_sign_o=1, alu_src_imm_o=1, alu_ctr_o=000, reg_wr_o=0; all other outputs are 0.
- R6: Opcode 000100 (beq) gives branch_sel_o=1, alu_src_imm_o=0, alu_ctr_o=001, reg_wr_o=0 and mem_wr_o=0.
- R7: For beq, the unused outputs ext_sign_o, mem_to_reg_o and reg_dst_o are driven to 0.
- R8: branch_sel_o is 1 only for opcode 000100.
- R9: Any opcode outside the six listed encodings drives every output to 0.
- R10: Opcode 000000 with a function code other than 100000 or 100010 drives every output to 0.
- R11: For opcodes other than 000000, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction opcode field |
| funct_i | input | 6 | Instruction function field (used with opcode 000000 only) |
| branch_sel_o | output | 1 | Next-PC branch select, ANDed with ALU zero by the fetch unit |
| reg_dst_o | output | 1 | Destination register: 1 = rd field, 0 = rt field |
| reg_wr_o | output | 1 | Register file write enable |
| ext_sign_o | output | 1 | Immediate extension: 1 = sign, 0 = zero |
| alu_src_imm_o | output | 1 | ALU operand B: 1 = extended immediate, 0 = register rt |
| alu_ctr_o | output | 3 | ALU operation: 000 add, 001 subtract, 010 OR |
| mem_wr_o | output | 1 | Data memory write enable |
| mem_to_reg_o | output | 1 | Write-back source: 1 = memory data, 0 = ALU result |

## Verification
Each supported encoding is applied with a zero function field and also with a nonzero one. This separates real R-type decoding from a leak of the function field into I-type controls. Opcodes that differ from a supported one by a single bit are applied to show that matching uses the full field. The R-type opcode is applied with unknown function codes, including the one next to subtract, to show that the decoder falls back to all-zero outputs instead of a default ALU operation. The output vector for beq is compared bit by bit against the expected word, which shows that no write enable leaks through and that the unused selects stay at 0.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int unsigned OP_W     = 6;
  localparam int unsigned FN_W     = 6;
  localparam int unsigned ALU_W    = 3;
  localparam int unsigned CTL_W    = 7 + ALU_W;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OP_SW    = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;

  localparam logic [FN_W-1:0] FN_ADD   = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB   = 6'b100010;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'b000,
    ALU_SUB = 3'b001,
    ALU_OR  = 3'b010
  } alu_op_e;

  typedef enum logic [2:0] {
    CL_BAD,
    CL_RTYPE,
    CL_ORI,
    CL_LW,
    CL_SW,
    CL_BEQ
  } op_class_e;

  typedef struct packed {
    logic    branch;
    logic    reg_dst;
    logic    reg_wr;
    logic    ext_sign;
    logic    alu_src_imm;
    alu_op_e alu_ctr;
    logic    mem_wr;
    logic    mem_to_reg;
  } ctl_t;

  localparam ctl_t CTL_OFF = '{default: '0, alu_ctr: ALU_ADD};
endpackage

// File: rtl/ctl_op_class.sv
module ctl_op_class
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output op_class_e       class_o
);
  always_comb begin
    unique case (opcode_i)
      OP_RTYPE: class_o = CL_RTYPE;
      OP_ORI:   class_o = CL_ORI;
      OP_LW:    class_o = CL_LW;
      OP_SW:    class_o = CL_SW;
      OP_BEQ:   class_o = CL_BEQ;
      default:  class_o = CL_BAD;
    endcase
  end

  always_comb begin
    // R8
    beq_class_chk: assert ((class_o == CL_BEQ) == (opcode_i == OP_BEQ));
  end
endmodule

// File: rtl/ctl_funct_sel.sv
module ctl_funct_sel
  import ctl_pkg::*;
(
  input  logic [FN_W-1:0] funct_i,
  output logic            valid_o,
  output alu_op_e         alu_o
);
  always_comb begin
    valid_o = 1'b1;
    alu_o   = ALU_ADD;
    unique case (funct_i)
      FN_ADD:  alu_o = ALU_ADD;
      FN_SUB:  alu_o = ALU_SUB;
      default: valid_o = 1'b0;
    endcase
  end

  always_comb begin
    // R10
    funct_known_chk: assert (valid_o == ((funct_i == FN_ADD) || (funct_i == FN_SUB)));
  end
endmodule

// File: rtl/ctl_word_gen.sv
module ctl_word_gen
  import ctl_pkg::*;
(
  input  op_class_e class_i,
  input  logic      fn_valid_i,
  input  alu_op_e   fn_alu_i,
  output ctl_t      ctl_o
);
  always_comb begin
    ctl_o = CTL_OFF;
    unique case (class_i)
      CL_RTYPE: if (fn_valid_i) begin
        ctl_o.reg_dst = 1'b1;
        ctl_o.reg_wr  = 1'b1;
        ctl_o.alu_ctr = fn_alu_i;
      end
      CL_ORI: begin
        ctl_o.reg_wr      = 1'b1;
        ctl_o.alu_src_imm = 1'b1;
        ctl_o.alu_ctr     = ALU_OR;
      end
      CL_LW: begin
        ctl_o.reg_wr      = 1'b1;
        ctl_o.ext_sign    = 1'b1;
        ctl_o.alu_src_imm = 1'b1;
        ctl_o.mem_to_reg  = 1'b1;
      end
      CL_SW: begin
        ctl_o.mem_wr      = 1'b1;
        ctl_o.ext_sign    = 1'b1;
        ctl_o.alu_src_imm = 1'b1;
      end
      CL_BEQ: begin
        ctl_o.branch  = 1'b1;
        ctl_o.alu_ctr = ALU_SUB;
      end
      default: ctl_o = CTL_OFF;
    endcase
  end

  always_comb begin
    // R6
    beq_no_write_chk: assert (!ctl_o.branch || (!ctl_o.reg_wr && !ctl_o.mem_wr &&
                              !ctl_o.alu_src_imm && ctl_o.alu_ctr == ALU_SUB));
    // R7
    beq_unused_zero_chk: assert (!ctl_o.branch ||
                                 (!ctl_o.ext_sign && !ctl_o.mem_to_reg && !ctl_o.reg_dst));
    // R5
    single_write_chk: assert (!(ctl_o.reg_wr && ctl_o.mem_wr));
    // R4
    load_writes_reg_chk: assert (!ctl_o.mem_to_reg || ctl_o.reg_wr);
  end
endmodule

// File: rtl/ctl_main_decoder.sv
module ctl_main_decoder
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output logic             branch_sel_o,
  output logic             reg_dst_o,
  output logic             reg_wr_o,
  output logic             ext_sign_o,
  output logic             alu_src_imm_o,
  output logic [ALU_W-1:0] alu_ctr_o,
  output logic             mem_wr_o,
  output logic             mem_to_reg_o
);
  op_class_e op_class;
  logic      fn_valid;
  alu_op_e   fn_alu;
  ctl_t      ctl;

  ctl_op_class i_op_class (
    .opcode_i (opcode_i),
    .class_o  (op_class)
  );

  ctl_funct_sel i_funct_sel (
    .funct_i (funct_i),
    .valid_o (fn_valid),
    .alu_o   (fn_alu)
  );

  ctl_word_gen i_word_gen (
    .class_i    (op_class),
    .fn_valid_i (fn_valid),
    .fn_alu_i   (fn_alu),
    .ctl_o      (ctl)
  );

  assign branch_sel_o  = ctl.branch;
  assign reg_dst_o     = ctl.reg_dst;
  assign reg_wr_o      = ctl.reg_wr;
  assign ext_sign_o    = ctl.ext_sign;
  assign alu_src_imm_o = ctl.alu_src_imm;
  assign alu_ctr_o     = ctl.alu_ctr;
  assign mem_wr_o      = ctl.mem_wr;
  assign mem_to_reg_o  = ctl.mem_to_reg;

  always_comb begin
    // R9
    bad_op_quiet_chk: assert (op_class != CL_BAD ||
                              (!reg_wr_o && !mem_wr_o && !branch_sel_o));
  end
endmodule

// File: tb/test_ctl_main_decoder.sv
module test_ctl_main_decoder;
  logic clk;
  logic rst_n;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic br, dst, wr, ext, src, mw, m2r;
  logic [2:0] ctr;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // packed expected word: {branch, reg_dst, reg_wr, ext_sign, alu_src_imm, alu_ctr[2:0], mem_wr, mem_to_reg}
  localparam int N = 16;
  localparam logic [21:0] VEC [N] = '{
    {6'b000000, 6'b100000, 10'b0_1_1_0_0_000_0_0}, // R1 add
    {6'b000000, 6'b100010, 10'b0_1_1_0_0_001_0_0}, // R2 sub
    {6'b001101, 6'b000000, 10'b0_0_1_0_1_010_0_0}, // R3 ori
    {6'b001101, 6'b100010, 10'b0_0_1_0_1_010_0_0}, // R11 ori, funct ignored
    {6'b100011, 6'b000000, 10'b0_0_1_1_1_000_0_1}, // R4 lw
    {6'b100011, 6'b111111, 10'b0_0_1_1_1_000_0_1}, // R11 lw, funct ignored
    {6'b101011, 6'b000000, 10'b0_0_0_1_1_000_1_0}, // R5 sw
    {6'b101011, 6'b100000, 10'b0_0_0_1_1_000_1_0}, // R11 sw, funct ignored
    {6'b000100, 6'b000000, 10'b1_0_0_0_0_001_0_0}, // R6 R7 beq
    {6'b000100, 6'b100000, 10'b1_0_0_0_0_001_0_0}, // R11 beq, funct ignored
    {6'b000101, 6'b000000, 10'b0_0_0_0_0_000_0_0}, // R8 R9 near-beq
    {6'b100001, 6'b000000, 10'b0_0_0_0_0_000_0_0}, // R9
    {6'b001100, 6'b000000, 10'b0_0_0_0_0_000_0_0}, // R9 near-ori
    {6'b000000, 6'b100011, 10'b0_0_0_0_0_000_0_0}, // R10 near-sub
    {6'b000000, 6'b100100, 10'b0_0_0_0_0_000_0_0}, // R10
    {6'b111111, 6'b100000, 10'b0_0_0_0_0_000_0_0}  // R9
  };

  ctl_main_decoder i_ctl_main_decoder (
    .opcode_i      (opcode),
    .funct_i       (funct),
    .branch_sel_o  (br),
    .reg_dst_o     (dst),
    .reg_wr_o      (wr),
    .ext_sign_o    (ext),
    .alu_src_imm_o (src),
    .alu_ctr_o     (ctr),
    .mem_wr_o      (mw),
    .mem_to_reg_o  (m2r)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic apply_check(input logic [5:0] op, input logic [5:0] fn,
                             input logic [9:0] exp, input string req);
    logic [9:0] got;
    @(posedge clk);
    opcode = op;
    funct  = fn;
    @(negedge clk);
    got = {br, dst, wr, ext, src, ctr, mw, m2r};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", req, op, fn, got, exp);
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    opcode = 6'b000000;
    funct  = 6'b000000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10 start-up state: op 0, funct 0 is outside the subset
    apply_check(6'b000000, 6'b000000, 10'b0, "R10");

    for (int i = 0; i < N; i++) begin
      string tag;
      tag = (i < 2) ? (i == 0 ? "R1" : "R2") : (i < 4) ? "R3/R11" :
            (i < 6) ? "R4/R11" : (i < 8) ? "R5/R11" : (i < 10) ? "R6/R7" : "R8/R9/R10";
      apply_check(VEC[i][21:16], VEC[i][15:10], VEC[i][9:0], tag);
    end

    // R8: branch select only for opcode 000100, sweep all opcodes
    for (int op = 0; op < 64; op++) begin
      @(posedge clk);
      opcode = op[5:0];
      funct  = 6'b100000;
      @(negedge clk);
      checks++;
      if (br !== (op == 4)) begin
        errors++;
        $display("FAIL R8 op=%0d actual=%b expected=%b", op, br, (op == 4));
      end
    end

    // R6: back-to-back sub then beq keeps subtract but drops writes
    apply_check(6'b000000, 6'b100010, 10'b0_1_1_0_0_001_0_0, "R2");
    apply_check(6'b000100, 6'b100010, 10'b1_0_0_0_0_001_0_0, "R6");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule